// File: doc/BRIEF.md
# Dual-Channel Fetch/Store DMA Engine

This block moves data on a 20-bit address bus on behalf of two independent channels. Each channel holds a source pointer, a destination pointer, a 16-bit transfer count and a control word. Every transfer is a pair of bus cycles. The engine first reads from the source into an internal holding register. It then writes that value to the destination. Each pointer can then step up, step down or stay where it is. The step is one for byte transfers and two for word transfers.

Software programs a channel through a small register port and sets its run bit. From then on, a peripheral paces the channel by holding its request line high. The request passes through a two-flop synchronizer first. The engine asks for the bus with `bus_req`, and it starts a transfer only in a cycle where `bus_gnt` is high. Arbitration against other masters happens outside the block.

Top module: `dual_dma_engine`

## Requirements
- R1: There are two channels, selected by `reg_addr[3]`. The offsets in `reg_addr[2:0]` are: 0 = source bits 15:0, 1 = source bits 19:16, 2 = destination bits 15:0, 3 = destination bits 19:16, 4 = count, 5 = control. Other offsets read as zero. Each channel's pointers are independent of the other channel.
- R2: Each pointer has its own 2-bit mode: 0 = hold, 1 = increment, 2 = decrement, 3 = hold. The pointer changes only after a completed store. The step is 2 when the word bit is set and 1 otherwise. The arithmetic wraps modulo 2^20, and odd addresses are allowed.
- R3: A transfer is a read cycle (`bus_rd`) followed directly by a write cycle (`bus_wr`). Each cycle lasts BUS_CLKS clocks (4 by default). The value on `bus_rdata` in the last read clock is the value driven on `bus_wdata` during the write. `bus_rd` and `bus_wr` are never both high.
- R4: Control bit 8 selects I/O space (1) or memory space (0) for the source. Control bit 9 does the same for the destination. `bus_io` follows the selected bit during the corresponding cycle, so all four combinations of spaces are allowed.
- R5: The count (offset 4) decreases by one, modulo 2^16, at every completed store.
- R6: The control word has these bits: 0 = run, 1 = stop-at-zero, 2 = word, 3 = priority, 5:4 = source mode, 7:6 = destination mode. When stop-at-zero is set and a store takes the count from 1 to 0, the run bit clears.
- R7: Reset clears every register, including the run bits. It also abandons any transfer in progress and drops all bus strobes.
- R8: A request line counts only after two clock edges of synchronization, and only while it is high. A running channel whose request is low performs no transfer.
- R9: When both channels are eligible and their priority bits differ, the channel whose priority bit is 1 is served.
- R10: When both channels are eligible and their priority bits are equal, the channels alternate after each completed transfer. Channel 0 is first after reset.
- R11: If a channel's run bit is clear while its transfer is in the read or write phase, the engine returns to idle on the next clock. No write is issued, the held data is discarded, and the pointers and count are left unchanged.
- R12: A transfer starts only in a cycle where `bus_gnt` is high. `bus_req` is high while a transfer is in progress or while any channel is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel select (bit 3) and register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| drq | input | 2 | Level-sensitive request, one bit per channel |
| bus_gnt | input | 1 | Bus grant from the external arbiter |
| bus_req | output | 1 | Bus request |
| bus_rd | output | 1 | Read (fetch) strobe |
| bus_wr | output | 1 | Write (store) strobe |
| bus_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_word | output | 1 | 1 = word transfer, 0 = byte transfer |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |

## Verification
A corrupt pointer shows on `bus_addr` in the very next read or write cycle of that channel. A wrong phase counter or a wrong state shows as a strobe that is too long, too short or out of order, and it shows within one clock. A wrong arbitration choice shows up at the start of the next transfer, as the wrong source address. A bad count or stop-at-zero decision shows as one transfer too many or too few, and it also shows in the count and control words read back over the register port.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int NCH = 2;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FETCH = 2'd1, ST_STORE = 2'd2} xfer_state_e;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [CW-1:0] cnt;
    logic          run;
    logic          tc;
    logic          word;
    logic          prio;
    logic [1:0]    smode;
    logic [1:0]    dmode;
    logic          sio;
    logic          dio;
  } chan_cfg_t;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p, input logic [1:0] mode,
                                             input logic word);
    logic [AW-1:0] st;
    st = word ? AW'(2) : AW'(1);
    case (mode)
      2'd1:    step_ptr = p + st;
      2'd2:    step_ptr = p - st;
      default: step_ptr = p;
    endcase
  endfunction

  function automatic logic [DW-1:0] ctl_word(input chan_cfg_t c);
    ctl_word = {6'd0, c.dio, c.sio, c.dmode, c.smode, c.prio, c.word, c.tc, c.run};
  endfunction
endpackage

// File: rtl/dmx_sync.sv
module dmx_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
  import dmx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic          done,
  output chan_cfg_t     cfg
);
  chan_cfg_t cfg_d;
  logic      hits_zero;

  assign hits_zero = done && cfg.tc && (cfg.cnt == CW'(1));

  always_comb begin
    cfg_d = cfg;
    if (wr_en) begin
      case (wr_off)
        3'd0: cfg_d.src[15:0]    = wr_data;
        3'd1: cfg_d.src[AW-1:16] = wr_data[AW-17:0];
        3'd2: cfg_d.dst[15:0]    = wr_data;
        3'd3: cfg_d.dst[AW-1:16] = wr_data[AW-17:0];
        3'd4: cfg_d.cnt          = wr_data;
        3'd5: begin
          cfg_d.run   = wr_data[0];
          cfg_d.tc    = wr_data[1];
          cfg_d.word  = wr_data[2];
          cfg_d.prio  = wr_data[3];
          cfg_d.smode = wr_data[5:4];
          cfg_d.dmode = wr_data[7:6];
          cfg_d.sio   = wr_data[8];
          cfg_d.dio   = wr_data[9];
        end
        default: ;
      endcase
    end
    if (done) begin
      cfg_d.src = step_ptr(cfg.src, cfg.smode, cfg.word);
      cfg_d.dst = step_ptr(cfg.dst, cfg.dmode, cfg.word);
      cfg_d.cnt = cfg.cnt - CW'(1);
      if (hits_zero) cfg_d.run = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else        cfg <= cfg_d;
  end

  a_r7_stopped_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !cfg.run);
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cfg.cnt == $past(cfg.cnt) - CW'(1));
  a_r6_tc_stop: assert property (@(posedge clk) disable iff (!rst_n)
    hits_zero |=> !cfg.run);
  a_r2_hold_src: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg.smode == 2'd0) |=> $stable(cfg.src));
endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
  import dmx_pkg::*;
#(
  parameter int BUS_CLKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chan_cfg_t     cfg [NCH],
  input  logic [NCH-1:0] drq_s,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic [NCH-1:0] done
);
  localparam int PW = (BUS_CLKS > 1) ? $clog2(BUS_CLKS) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(BUS_CLKS - 1);

  xfer_state_e   state;
  logic [PW-1:0] ph;
  logic          cur, last_served, pick;
  logic [DW-1:0] hold_q;
  logic [NCH-1:0] elig;
  logic          start_xfer, cur_live, phase_end, abort_x, store_end;

  assign elig       = {cfg[1].run & drq_s[1], cfg[0].run & drq_s[0]};
  assign start_xfer = (state == ST_IDLE) && (|elig) && bus_gnt;
  assign cur_live   = cfg[cur].run;
  assign phase_end  = (ph == LAST_PH);
  assign abort_x    = (state != ST_IDLE) && !cur_live;
  assign store_end  = (state == ST_STORE) && phase_end && cur_live;
  assign done       = {store_end && cur, store_end && !cur};

  always_comb begin
    if (elig == 2'b11) pick = (cfg[0].prio != cfg[1].prio) ? cfg[1].prio : ~last_served;
    else               pick = elig[1] & ~elig[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; ph <= '0; cur <= 1'b0; last_served <= 1'b1; hold_q <= '0;
    end else if (abort_x) begin
      state <= ST_IDLE; ph <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_xfer) begin
          state <= ST_FETCH; ph <= '0; cur <= pick;
        end
        ST_FETCH: if (phase_end) begin
          hold_q <= bus_rdata; state <= ST_STORE; ph <= '0;
        end else ph <= ph + PW'(1);
        ST_STORE: if (phase_end) begin
          state <= ST_IDLE; ph <= '0; last_served <= cur;
        end else ph <= ph + PW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rd    = (state == ST_FETCH);
    bus_wr    = (state == ST_STORE);
    bus_req   = (state != ST_IDLE) || (|elig);
    bus_word  = (state != ST_IDLE) && cfg[cur].word;
    bus_io    = bus_rd ? cfg[cur].sio : (bus_wr ? cfg[cur].dio : 1'b0);
    bus_addr  = bus_rd ? cfg[cur].src : (bus_wr ? cfg[cur].dst : '0);
    bus_wdata = bus_wr ? hold_q : '0;
  end

  a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r3_fetch_then_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && phase_end && cur_live) |=> bus_wr);
  a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_x |=> !bus_rd && !bus_wr);
  a_r9_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (start_xfer && elig == 2'b11 && cfg[0].prio != cfg[1].prio) |=> cur == $past(cfg[1].prio));
  a_r10_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (start_xfer && elig == 2'b11 && cfg[0].prio == cfg[1].prio) |=> cur != $past(last_served));
  a_r12_grant_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !bus_gnt) |=> !bus_rd);
endmodule

// File: rtl/dual_dma_engine.sv
module dual_dma_engine
  import dmx_pkg::*;
#(
  parameter int BUS_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [1:0]  drq,
  input  logic        bus_gnt,
  output logic        bus_req,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic        bus_io,
  output logic        bus_word,
  output logic [19:0] bus_addr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata
);
  chan_cfg_t      ch_cfg [NCH];
  logic [NCH-1:0] drq_s;
  logic [NCH-1:0] ch_done;
  chan_cfg_t      sel;

  dmx_sync #(.W(NCH)) u_sync (.clk(clk), .rst_n(rst_n), .d(drq), .q(drq_s));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmx_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we && (reg_addr[3] == 1'(c))),
      .wr_off(reg_addr[2:0]), .wr_data(reg_wdata),
      .done(ch_done[c]), .cfg(ch_cfg[c])
    );
  end

  dmx_seq #(.BUS_CLKS(BUS_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(ch_cfg), .drq_s(drq_s), .bus_gnt(bus_gnt),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_io(bus_io), .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .done(ch_done)
  );

  always_comb begin
    sel = ch_cfg[reg_addr[3]];
    case (reg_addr[2:0])
      3'd0:    reg_rdata = sel.src[15:0];
      3'd1:    reg_rdata = {{(DW-(AW-16)){1'b0}}, sel.src[AW-1:16]};
      3'd2:    reg_rdata = sel.dst[15:0];
      3'd3:    reg_rdata = {{(DW-(AW-16)){1'b0}}, sel.dst[AW-1:16]};
      3'd4:    reg_rdata = sel.cnt;
      3'd5:    reg_rdata = ctl_word(sel);
      default: reg_rdata = '0;
    endcase
  end

  a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !bus_rd && !bus_wr);
endmodule

// File: tb/dual_dma_engine_tb.sv
module dual_dma_engine_tb;
  logic        clk = 0, rst_n = 0, reg_we = 0, bus_gnt = 0;
  logic [3:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata, bus_wdata, bus_rdata;
  logic [1:0]  drq = 0;
  logic        bus_req, bus_rd, bus_wr, bus_io, bus_word;
  logic [19:0] bus_addr;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  assign bus_rdata = bus_addr[15:0] ^ (bus_io ? 16'hA5A5 : 16'h3C3C);

  dual_dma_engine u_dut (.*);

  // behavioural reference model
  bit [19:0] m_src[2], m_dst[2];
  bit [15:0] m_cnt[2], m_latch;
  bit        m_run[2], m_tc[2], m_word[2], m_prio[2], m_sio[2], m_dio[2];
  bit [1:0]  m_sm[2], m_dm[2];
  bit [1:0]  m_s1, m_s2;
  int        m_st, m_ph, m_cur, m_last;
  int        fetch_q[$];
  bit        prev_rd;

  function automatic bit [19:0] mstep(bit [19:0] p, bit [1:0] md, bit w);
    int s = w ? 2 : 1;
    if (md == 1) return 20'((p + s) & 20'hFFFFF);
    if (md == 2) return 20'((p - s) & 20'hFFFFF);
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0; m_run[c] = 0; m_tc[c] = 0; m_word[c] = 0;
        m_prio[c] = 0; m_sio[c] = 0; m_dio[c] = 0; m_sm[c] = 0; m_dm[c] = 0;
      end
      m_s1 = 0; m_s2 = 0; m_st = 0; m_ph = 0; m_cur = 0; m_last = 1; m_latch = 0;
    end else begin
      bit e0, e1, otc;
      int dn, c;
      bit [15:0] ocnt;
      e0 = m_run[0] && m_s2[0]; e1 = m_run[1] && m_s2[1]; dn = -1;
      case (m_st)
        0: if ((e0 || e1) && bus_gnt) begin
          if (e0 && e1) m_cur = (m_prio[0] != m_prio[1]) ? int'(m_prio[1]) : 1 - m_last;
          else m_cur = e1 ? 1 : 0;
          m_st = 1; m_ph = 0;
        end
        1: if (!m_run[m_cur]) m_st = 0;
           else if (m_ph == 3) begin
             m_latch = m_src[m_cur][15:0] ^ (m_sio[m_cur] ? 16'hA5A5 : 16'h3C3C);
             m_st = 2; m_ph = 0;
           end else m_ph++;
        default: if (!m_run[m_cur]) m_st = 0;
           else if (m_ph == 3) begin dn = m_cur; m_last = m_cur; m_st = 0; m_ph = 0; end
           else m_ph++;
      endcase
      c = reg_addr[3];
      otc = m_tc[c]; ocnt = m_cnt[c];
      if (dn >= 0) begin otc = m_tc[dn]; ocnt = m_cnt[dn]; end
      if (reg_we) begin
        case (reg_addr[2:0])
          0: m_src[c][15:0] = reg_wdata;
          1: m_src[c][19:16] = reg_wdata[3:0];
          2: m_dst[c][15:0] = reg_wdata;
          3: m_dst[c][19:16] = reg_wdata[3:0];
          4: m_cnt[c] = reg_wdata;
          5: begin
            m_run[c] = reg_wdata[0]; m_tc[c] = reg_wdata[1]; m_word[c] = reg_wdata[2];
            m_prio[c] = reg_wdata[3]; m_sm[c] = reg_wdata[5:4]; m_dm[c] = reg_wdata[7:6];
            m_sio[c] = reg_wdata[8]; m_dio[c] = reg_wdata[9];
          end
          default: ;
        endcase
      end
      if (dn >= 0) begin
        // step uses pre-update mode/word; writes to the same channel are avoided by the stimulus
        m_src[dn] = mstep(m_src[dn], m_sm[dn], m_word[dn]);
        m_dst[dn] = mstep(m_dst[dn], m_dm[dn], m_word[dn]);
        m_cnt[dn] = ocnt - 16'd1;
        if (otc && ocnt == 16'd1) m_run[dn] = 0;
      end
      m_s2 = m_s1; m_s1 = drq;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    bit xr, xw, xq, xio, xwd;
    bit [19:0] xa;
    bit [15:0] xd;
    #1;
    cyc++;
    xr = (m_st == 1); xw = (m_st == 2);
    xq = (m_st != 0) || (m_run[0] && m_s2[0]) || (m_run[1] && m_s2[1]);
    xio = xr ? m_sio[m_cur] : (xw ? m_dio[m_cur] : 1'b0);
    xa = xr ? m_src[m_cur] : (xw ? m_dst[m_cur] : 20'd0);
    xwd = (m_st != 0) && m_word[m_cur];
    xd = xw ? m_latch : 16'd0;
    checks++;
    if ({bus_rd, bus_wr, bus_req, bus_io, bus_word} !== {xr, xw, xq, xio, xwd} ||
        bus_addr !== xa || bus_wdata !== xd) begin
      errors++;
      $display("FAIL R3/R12 cycle %0d: rd%b wr%b req%b io%b w%b a%h d%h exp rd%b wr%b req%b io%b w%b a%h d%h",
               cyc, bus_rd, bus_wr, bus_req, bus_io, bus_word, bus_addr, bus_wdata,
               xr, xw, xq, xio, xwd, xa, xd);
    end
    if (bus_rd && !prev_rd) fetch_q.push_back(int'(bus_addr[19:16]));
    prev_rd = bus_rd;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input bit [3:0] a, input bit [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rdchk(input bit [3:0] a, input bit [15:0] e, input string tag);
    @(negedge clk); reg_addr = a; #1;
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s: reg %0d read %h expected %h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic prog(input bit ch, input bit [19:0] s, input bit [19:0] d, input bit [15:0] n,
                      input bit [15:0] ctl);
    bit [3:0] b = {ch, 3'b000};
    wr(b + 0, s[15:0]); wr(b + 1, {12'd0, s[19:16]});
    wr(b + 2, d[15:0]); wr(b + 3, {12'd0, d[19:16]});
    wr(b + 4, n); wr(b + 5, ctl);
  endtask

  task automatic order_chk(input int e0, input int e1, input int e2, input int e3,
                           input string tag);
    int exp[4] = '{e0, e1, e2, e3};
    checks++;
    if (fetch_q.size() != 4 || fetch_q[0] != exp[0] || fetch_q[1] != exp[1] ||
        fetch_q[2] != exp[2] || fetch_q[3] != exp[3]) begin
      errors++;
      $display("FAIL %s: fetch order %p expected %p", tag, fetch_q, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7: reset state
    rdchk(4'h5, 16'h0000, "R7 ch0 run clear");
    rdchk(4'hD, 16'h0000, "R7 ch1 run clear");
    rdchk(4'h6, 16'h0000, "R1 unused offset");
    // R2/R4/R5/R6: ch0 byte, src inc memory, dst hold I/O, 3 transfers
    bus_gnt = 1; drq = 2'b01;
    prog(0, 20'h12345, 20'h00100, 16'd3, 16'h0213);
    repeat (60) @(negedge clk);
    rdchk(4'h0, 16'h2348, "R2 src inc byte");
    rdchk(4'h1, 16'h0001, "R1 src high");
    rdchk(4'h2, 16'h0100, "R2 dst hold");
    rdchk(4'h4, 16'h0000, "R5 count");
    rdchk(4'h5, 16'h0212, "R6 stop at zero");
    // R2: ch1 word, src dec from odd address, dst inc wraps
    drq = 2'b10;
    prog(1, 20'h00011, 20'hFFFFF, 16'd2, 16'h0067);
    repeat (50) @(negedge clk);
    rdchk(4'h8, 16'h000D, "R2 src dec word odd");
    rdchk(4'hA, 16'h0003, "R2 dst wrap");
    rdchk(4'hB, 16'h0000, "R2 dst high wrap");
    rdchk(4'hD, 16'h0066, "R6 ch1 stopped");
    // R10/R12: equal priority alternates; programmed with grant low
    bus_gnt = 0; drq = 2'b11;
    prog(0, 20'h10000, 20'h00200, 16'd2, 16'h0013);
    prog(1, 20'h20000, 20'h00300, 16'd2, 16'h0013);
    repeat (4) @(negedge clk);
    checks++;
    if (bus_rd !== 0 || bus_req !== 1) begin
      errors++; $display("FAIL R12: rd %b req %b expected 0 1", bus_rd, bus_req);
    end
    fetch_q.delete();
    bus_gnt = 1;
    repeat (60) @(negedge clk);
    order_chk(1, 2, 1, 2, "R10 alternate");
    // R9: ch1 higher priority served first
    bus_gnt = 0;
    prog(0, 20'h10000, 20'h00200, 16'd2, 16'h0013);
    prog(1, 20'h20000, 20'h00300, 16'd2, 16'h001B);
    fetch_q.delete();
    bus_gnt = 1;
    repeat (60) @(negedge clk);
    order_chk(2, 2, 1, 1, "R9 priority");
    // R11: stop during store
    drq = 2'b01;
    prog(0, 20'h30000, 20'h00400, 16'd5, 16'h0011);
    wait (bus_wr);
    wr(4'h5, 16'h0010);
    repeat (10) @(negedge clk);
    rdchk(4'h4, 16'h0005, "R11 count untouched");
    rdchk(4'h0, 16'h0000, "R11 src untouched");
    // R8: low request ignored
    drq = 2'b00;
    prog(0, 20'h40000, 20'h00500, 16'd1, 16'h0013);
    repeat (20) @(negedge clk);
    rdchk(4'h4, 16'h0001, "R8 no request no transfer");
    drq = 2'b01;
    repeat (20) @(negedge clk);
    rdchk(4'h4, 16'h0000, "R8 request served");
    // R7: reset mid-transfer
    prog(0, 20'h50000, 20'h00600, 16'd4, 16'h0013);
    wait (bus_rd);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rdchk(4'h5, 16'h0000, "R7 run cleared by reset");
    checks++;
    if (bus_rd !== 0 || bus_wr !== 0) begin
      errors++; $display("FAIL R7: rd %b wr %b expected 0 0", bus_rd, bus_wr);
    end
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule